// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer operand by another over several clock cycles, producing one quotient bit per cycle with the restoring method. A single accumulator register carries the partial remainder in its upper part and collects quotient bits in its lower part as it shifts left. One subtractor, a single bit wider than the divisor, decides each quotient bit. The last step halves the upper part to recover the remainder.

A caller presents the two operands and a mode bit, then pulses `start` for one cycle. When `signed_mode` is set, the block records the operand signs and divides their magnitudes. It then fixes up the result signs, so the quotient rounds toward zero. The results and a divide-by-zero flag stay on the outputs until the next operation finishes. `done` marks the single cycle in which a fresh result first appears. A request is accepted only when the block is idle, and the cycle that carries `done` counts as idle.

Top module: `seq_restoring_divider`

## Requirements
- R1: Unsigned mode (`signed_mode`=0) with a nonzero divisor: `quotient` is the floor of dividend/divisor and `remainder` is dividend minus quotient times divisor, always below the divisor.
- R2: Signed mode (`signed_mode`=1, two's complement operands) with a nonzero divisor: `quotient` is the true quotient truncated toward zero, so it is negative exactly when the operand signs differ and the magnitude is nonzero.
- R3: Signed mode: `remainder` carries the sign of the dividend (or is zero) and its magnitude is below the divisor magnitude. For example, -7 divided by 2 yields -3 with remainder -1.
- R4: Signed mode, most negative dividend divided by -1: `quotient` wraps to the most negative value and `remainder` is zero.
- R5: A zero divisor in either mode: `done` rises on the clock edge after acceptance, `div_by_zero` is 1, `quotient` is all ones and `remainder` equals the raw dividend.
- R6: With a nonzero divisor, `done` rises exactly W+1 clock edges after the accepting edge (W iterations plus one finishing cycle), and `div_by_zero` reads 0 with that result.
- R7: `done` is high for one cycle per completed operation. `quotient`, `remainder` and `div_by_zero` hold their values until the next completion.
- R8: A `start` pulse that arrives while an operation is in progress, including its finishing cycle, is ignored. It has no effect on that result and launches no operation of its own.
- R9: A `start` pulse in the same cycle as `done` is accepted and begins a new operation.
- R10: After synchronous reset, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a division |
| signed_mode | input | 1 | 1: two's complement operands; 0: unsigned |
| dividend | input | W | Numerator, captured on the accepting edge |
| divisor | input | W | Denominator, captured on the accepting edge |
| quotient | output | W | Quotient of the last completed operation |
| remainder | output | W | Remainder of the last completed operation |
| done | output | 1 | One-cycle marker of a newly completed result |
| div_by_zero | output | 1 | Set when the last completed operation had a zero divisor |

## Verification
Two events can land in the same cycle: a completion (`done`) and a new request (`start`). The first is judged by launching a second division, signed or with a zero divisor, in the very cycle `done` is seen. The bench then checks that the new result arrives after the normal latency from that edge, while the previous result was intact when `done` was sampled. The rejected case is provoked by pulsing `start` with different operands in the middle of a run and again in the finishing cycle. It is judged by the original result and latency, and by the absence of any further `done` afterwards.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic quo_neg;
        logic rem_neg;
    } sign_rec_t;

    // The remainder follows the dividend; the quotient is negative when the signs differ.
    function automatic sign_rec_t derive_signs(input logic mode,
                                               input logic a_msb,
                                               input logic b_msb);
        sign_rec_t s;
        s.rem_neg = mode & a_msb;
        s.quo_neg = mode & (a_msb ^ b_msb);
        return s;
    endfunction

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            signed_mode,
    input  logic [W-1:0]    dividend,
    input  logic [W-1:0]    divisor,
    output logic [W-1:0]    mag_a,
    output logic [W-1:0]    mag_b,
    output sign_rec_t       signs
);

    logic neg_a;
    logic neg_b;

    always_comb begin
        neg_a = signed_mode & dividend[W-1];
        neg_b = signed_mode & divisor[W-1];
        // The most negative value negates to itself, which is its correct magnitude unsigned.
        mag_a = neg_a ? -dividend : dividend;
        mag_b = neg_b ? -divisor  : divisor;
        signs = derive_signs(signed_mode, dividend[W-1], divisor[W-1]);
    end

endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
    parameter int W = 32,
    localparam int AW = 2*W + 1
) (
    input  logic [AW-1:0] acc,
    input  logic [W-1:0]  dvs,
    output logic [AW-1:0] acc_next,
    output logic          spill
);

    logic [W:0]   hi;
    logic [W+1:0] diff;
    logic         take;
    logic [W:0]   new_hi;

    always_comb begin
        hi     = acc[2*W:W];
        diff   = {1'b0, hi} - {2'b00, dvs};
        take   = ~diff[W+1];
        new_hi = take ? diff[W:0] : hi;
        // Shift the whole accumulator left, feeding the new quotient bit in at the bottom.
        acc_next = {new_hi[W-1:0], acc[W-1:0], take};
        spill    = new_hi[W];
    end

endmodule

// File: rtl/div_result_fix.sv
module div_result_fix
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_part,
    input  logic [W-1:0] quo_part,
    input  sign_rec_t    signs,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);

    always_comb begin
        quo = signs.quo_neg ? -quo_part : quo_part;
        rem = signs.rem_neg ? -rem_part : rem_part;
    end

endmodule

// File: rtl/seq_restoring_divider.sv
module seq_restoring_divider
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         done,
    output logic         div_by_zero
);

    localparam int AW = 2*W + 1;
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e     state;
    logic [AW-1:0]  acc;
    logic [W-1:0]   dvs_q;
    sign_rec_t      signs_q;
    logic [CW-1:0]  cnt;
    logic           busy;

    logic [W-1:0]   mag_a;
    logic [W-1:0]   mag_b;
    sign_rec_t      signs_in;
    logic [AW-1:0]  acc_next;
    logic           step_spill;
    logic [W-1:0]   fix_quo;
    logic [W-1:0]   fix_rem;

    assign busy = (state != ST_IDLE);

    div_operand_prep #(.W(W)) u_prep (
        .signed_mode (signed_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .mag_a       (mag_a),
        .mag_b       (mag_b),
        .signs       (signs_in)
    );

    div_restore_step #(.W(W)) u_step (
        .acc      (acc),
        .dvs      (dvs_q),
        .acc_next (acc_next),
        .spill    (step_spill)
    );

    // The upper part holds twice the remainder, so dropping its lowest bit halves it.
    div_result_fix #(.W(W)) u_fix (
        .rem_part (acc[2*W:W+1]),
        .quo_part (acc[W-1:0]),
        .signs    (signs_q),
        .quo      (fix_quo),
        .rem      (fix_rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            acc         <= '0;
            dvs_q       <= '0;
            signs_q     <= '0;
            cnt         <= '0;
            quotient    <= '0;
            remainder   <= '0;
            done        <= 1'b0;
            div_by_zero <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (divisor == '0) begin
                            quotient    <= '1;
                            remainder   <= dividend;
                            div_by_zero <= 1'b1;
                            done        <= 1'b1;
                        end else begin
                            // Load the magnitude, already shifted left by one place.
                            acc     <= {{W{1'b0}}, mag_a, 1'b0};
                            dvs_q   <= mag_b;
                            signs_q <= signs_in;
                            cnt     <= '0;
                            state   <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    acc <= acc_next;
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        state <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    quotient    <= fix_quo;
                    remainder   <= fix_rem;
                    div_by_zero <= 1'b0;
                    done        <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/div_checker.sv
module div_checker
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] divisor,
    input logic         busy,
    input div_state_e   state,
    input logic         done,
    input logic         dbz,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic [W-1:0] dvs_q,
    input logic         rem_neg,
    input logic         spill
);

    // R1: the guard bit of the upper part is never lost by a shift
    a_r1_no_spill: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> !spill);

    // R1: a non-negated remainder stays below the divisor magnitude
    a_r1_rem_bound: assert property (@(posedge clk) disable iff (rst)
        (done && !dbz && !rem_neg) |-> (remainder < dvs_q));

    // R3: a negated remainder is zero or negative
    a_r3_rem_sign: assert property (@(posedge clk) disable iff (rst)
        (done && !dbz && rem_neg) |-> (remainder == '0 || remainder[W-1]));

    // R5: zero divisor finishes on the next edge with the flag and all-ones quotient
    a_r5_zero_divisor: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && divisor == '0) |=> (done && dbz && quotient == '1));

    // R6: the finishing cycle produces a result with the flag clear
    a_r6_finish: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN) |=> (done && !dbz));

    // R7: the flag only changes together with a completion
    a_r7_flag_stable: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(dbz));

    // R9: a completion leaves the block idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: the captured divisor does not move while an operation runs
    a_r8_hold_divisor: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(dvs_q));

endmodule

bind seq_restoring_divider div_checker #(.W(W)) u_div_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .divisor   (divisor),
    .busy      (busy),
    .state     (state),
    .done      (done),
    .dbz       (div_by_zero),
    .quotient  (quotient),
    .remainder (remainder),
    .dvs_q     (dvs_q),
    .rem_neg   (signs_q.rem_neg),
    .spill     (step_spill)
);

// File: tb/seq_restoring_divider_bench.sv
`timescale 1ns/1ps
module seq_restoring_divider_bench;

    localparam int W = 4;
    localparam int LAT = W + 2;   // negedge count from the launch negedge, inclusive of the one after it

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         done;
    logic         div_by_zero;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    seq_restoring_divider #(.W(W)) u_seq_restoring_divider (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .signed_mode (signed_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .quotient    (quotient),
        .remainder   (remainder),
        .done        (done),
        .div_by_zero (div_by_zero)
    );

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    task automatic expect_of(input bit s, input logic [W-1:0] a, input logic [W-1:0] b,
                             output logic [W-1:0] q, output logic [W-1:0] r,
                             output logic z, output string tag);
        int ia;
        int ib;
        if (b == '0) begin
            q = '1; r = a; z = 1'b1; tag = "R5";
        end else begin
            ia = s ? int'($signed(a)) : int'(a);
            ib = s ? int'($signed(b)) : int'(b);
            q = W'(ia / ib);
            r = W'(ia % ib);
            z = 1'b0;
            if (!s) tag = "R1";
            else if (a == {1'b1, {(W-1){1'b0}}} && b == '1) tag = "R4";
            else tag = "R2/R3";
        end
    endtask

    // When now is set, the request is driven at the current negedge.
    task automatic launch(input bit now, input bit s, input logic [W-1:0] a, input logic [W-1:0] b);
        if (!now) @(negedge clk);
        signed_mode = s;
        dividend    = a;
        divisor     = b;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(inout int lat);
        while (!done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic judge(input bit s, input logic [W-1:0] a, input logic [W-1:0] b, input int lat);
        logic [W-1:0] eq;
        logic [W-1:0] er;
        logic ez;
        string tag;
        int elat;
        expect_of(s, a, b, eq, er, ez, tag);
        elat = (b == '0) ? 1 : LAT;
        check(lat == elat, (b == '0) ? "R5 latency" : "R6 latency",
              $sformatf("%0d", lat), $sformatf("%0d", elat));
        check(done && quotient == eq && remainder == er && div_by_zero == ez,
              $sformatf("%s s=%0d a=%h b=%h", tag, s, a, b),
              $sformatf("q=%h r=%h z=%0d", quotient, remainder, div_by_zero),
              $sformatf("q=%h r=%h z=%0d", eq, er, ez));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [W-1:0] qs;
        logic [W-1:0] rs;
        logic zs;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(!done && !div_by_zero && quotient == '0 && remainder == '0, "R10 reset",
              $sformatf("d=%0d z=%0d q=%h r=%h", done, div_by_zero, quotient, remainder),
              "d=0 z=0 q=0 r=0");

        // R1..R7: exhaustive sweep of both modes
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    launch(1'b0, s[0], W'(a), W'(b));
                    lat = 1;
                    wait_done(lat);
                    judge(s[0], W'(a), W'(b), lat);
                    qs = quotient; rs = remainder; zs = div_by_zero;
                    @(negedge clk);
                    // R7: single-cycle done, held outputs
                    check(!done && quotient == qs && remainder == rs && div_by_zero == zs,
                          "R7 pulse/hold",
                          $sformatf("d=%0d q=%h r=%h z=%0d", done, quotient, remainder, div_by_zero),
                          $sformatf("d=0 q=%h r=%h z=%0d", qs, rs, zs));
                end
            end
        end

        // R8: start mid-run with a zero divisor is ignored
        launch(1'b0, 1'b0, 4'd13, 4'd3);
        @(negedge clk);
        signed_mode = 1'b1; dividend = 4'd5; divisor = 4'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 3;
        wait_done(lat);
        judge(1'b0, 4'd13, 4'd3, lat);
        check(!div_by_zero && quotient == 4'd4, "R8 mid-run start ignored",
              $sformatf("q=%h z=%0d", quotient, div_by_zero), "q=4 z=0");

        // R8: start in the finishing cycle is ignored and launches nothing
        launch(1'b0, 1'b1, 4'hA, 4'd3);   // -6 / 3
        lat = 1;
        while (lat < LAT - 1) begin
            @(negedge clk);
            lat++;
        end
        signed_mode = 1'b0; dividend = 4'd1; divisor = 4'd0; start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        wait_done(lat);
        judge(1'b1, 4'hA, 4'd3, lat);
        lat = 0;
        repeat (LAT + 2) begin
            @(negedge clk);
            if (done) lat++;
        end
        check(lat == 0 && quotient == 4'hE && !div_by_zero, "R8 finish-cycle start ignored",
              $sformatf("extra=%0d q=%h z=%0d", lat, quotient, div_by_zero), "extra=0 q=e z=0");

        // R9: back-to-back requests in the done cycle
        launch(1'b0, 1'b0, 4'd9, 4'd2);
        lat = 1;
        wait_done(lat);
        judge(1'b0, 4'd9, 4'd2, lat);
        launch(1'b1, 1'b1, 4'h9, 4'd2);   // -7 / 2
        lat = 1;
        wait_done(lat);
        check(lat == LAT, "R9 back-to-back latency", $sformatf("%0d", lat), $sformatf("%0d", LAT));
        check(quotient == 4'hD && remainder == 4'hF && !div_by_zero, "R9/R3 -7 div 2",
              $sformatf("q=%h r=%h", quotient, remainder), "q=d r=f");
        launch(1'b1, 1'b0, 4'd6, 4'd0);
        lat = 1;
        wait_done(lat);
        check(lat == 1 && div_by_zero && quotient == 4'hF && remainder == 4'd6,
              "R9/R5 back-to-back zero divisor",
              $sformatf("lat=%0d z=%0d q=%h r=%h", lat, div_by_zero, quotient, remainder),
              "lat=1 z=1 q=f r=6");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule